// File: doc/BRIEF.md
# Hamming single-error-correcting codec (12-bit codeword)

The block protects one byte with four parity bits and packs them into a 12-bit codeword. Its encoder side is purely combinational: a data byte goes in and the codeword comes out in the same cycle. Its decoder side takes a received codeword together with a valid strobe. It recomputes the four parity checks into a syndrome and repairs a single flipped bit. It registers the result and presents it one clock later with its own valid strobe.

The block has no overall parity bit. A syndrome that names a position past the twelfth transmitted bit cannot be the result of a single error, so the decoder reports it as uncorrectable and leaves the data untouched. Some double errors and most larger error patterns alias onto a legal position. Those are "corrected" wrongly by design, and nothing in the block tries to tell them apart.

Top module: `hamm_sec_codec`

## Requirements
- R1: Codeword bit `p-1` holds position `p` (1..12). Positions 1, 2, 4 and 8 carry parity bits P0, P1, P2 and P3. Data bits D0..D7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that ascending order.
- R2: Each parity bit Pk makes the XOR of all positions whose binary index has bit k set equal to zero (even parity), so every encoder output decodes with syndrome 0.
- R3: Syndrome bit k is the XOR of all received positions whose index has bit k set. With syndrome 0 the decoder outputs the received data bits unchanged with both flags low.
- R4: For a syndrome of 1..12 the decoder inverts the bit at that position before extracting data. It raises the corrected flag and keeps the uncorrectable flag low. A single flipped bit at any of the 12 positions is therefore repaired and reported with the syndrome equal to its position.
- R5: For a syndrome of 13, 14 or 15 the decoder raises the uncorrectable flag and lowers the corrected flag. It outputs the received data bits with no inversion.
- R6: With both P0 and P1 flipped, the syndrome is 3 and the decoder inverts D0 while raising the corrected flag. This miscorrection is the specified behaviour.
- R7: The decoder's output valid equals its input valid delayed by exactly one clock. Data, syndrome and flags belong to the codeword accepted on that earlier edge.
- R8: On a clock where the input valid is low, the decoder's data, syndrome and flags keep their previous values.
- R9: While synchronous reset is high, every decoder output is zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 8 | Byte to encode |
| enc_code_o | output | 12 | Encoded codeword (combinational) |
| dec_valid_i | input | 1 | Received codeword is valid this cycle |
| dec_code_i | input | 12 | Received codeword |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | 8 | Decoded (possibly corrected) byte |
| dec_syndrome_o | output | 4 | Syndrome of the accepted codeword |
| dec_corrected_o | output | 1 | A bit was inverted |
| dec_uncorr_o | output | 1 | Syndrome beyond position 12 |

## Verification
Clean codewords from several byte patterns show that the encoder places bits correctly and that its parity yields a zero syndrome. A single flip walked over all twelve positions of more than one codeword shows that each position is located and repaired. Paired flips chosen to give syndromes 13, 14 and 15 separate the uncorrectable path from correction, and the P0+P1 pair confirms the specified miscorrection of D0. Idle gaps between accepted codewords tell the one-cycle valid lag apart from the hold of the previous result.

// File: rtl/hamm_pkg.sv
package hamm_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_PAR_W  = 4;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } dec_status_e;

    typedef struct packed {
        logic corrected;
        logic uncorrectable;
    } dec_flags_t;

    // Position p (1-based) holds a parity bit when p is a power of two.
    function automatic bit is_parity_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Data slot carried at a non-parity position p.
    function automatic int data_slot(int p);
        int n;
        n = 0;
        for (int q = 1; q < p; q++) begin
            if (!is_parity_pos(q)) n++;
        end
        return n;
    endfunction

    // Parity index of a power-of-two position.
    function automatic int parity_slot(int p);
        int k;
        k = 0;
        while ((1 << k) < p) k++;
        return k;
    endfunction

endpackage

// File: rtl/hamm_encoder.sv
module hamm_encoder
    import hamm_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PAR_W  = DEF_PAR_W,
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [PAR_W-1:0] par;

    always_comb begin
        par = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_parity_pos(p)) begin
                for (int k = 0; k < PAR_W; k++) begin
                    if (((p >> k) & 1) == 1) par[k] = par[k] ^ data_i[data_slot(p)];
                end
            end
        end
    end

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if (is_parity_pos(p)) begin : g_par
            assign code_o[p-1] = par[parity_slot(p)];
        end else begin : g_dat
            assign code_o[p-1] = data_i[data_slot(p)];
        end
    end

endmodule

// File: rtl/hamm_syndrome.sv
module hamm_syndrome #(
    parameter int CODE_W = 12,
    parameter int SYN_W  = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [SYN_W-1:0]  syn_o
);

    always_comb begin
        syn_o = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            for (int k = 0; k < SYN_W; k++) begin
                if (((p >> k) & 1) == 1) syn_o[k] = syn_o[k] ^ code_i[p-1];
            end
        end
    end

endmodule

// File: rtl/hamm_corrector.sv
module hamm_corrector
    import hamm_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PAR_W  = DEF_PAR_W,
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [PAR_W-1:0]  syn_i,
    output logic [DATA_W-1:0] data_o,
    output dec_status_e       status_o
);

    logic [CODE_W-1:0] fixed;
    logic              in_range;

    assign in_range = (syn_i != '0) && (int'(syn_i) <= CODE_W);

    always_comb begin
        fixed = code_i;
        if (syn_i == '0)   status_o = ST_CLEAN;
        else if (in_range) status_o = ST_FIXED;
        else               status_o = ST_BAD;
        for (int p = 1; p <= CODE_W; p++) begin
            if (in_range && int'(syn_i) == p) fixed[p-1] = ~code_i[p-1];
        end
    end

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pick
        if (!is_parity_pos(p)) begin : g_dat
            assign data_o[data_slot(p)] = fixed[p-1];
        end
    end

    always_comb begin
        AST_SINGLE_FLIP: assert ($countones(code_i ^ fixed) <= 1);                   // R4
        if (status_o == ST_BAD) AST_BAD_UNTOUCHED: assert (fixed == code_i);          // R5
        if (status_o == ST_CLEAN) AST_CLEAN_UNTOUCHED: assert (fixed == code_i);      // R3
    end

endmodule

// File: rtl/hamm_sec_codec.sv
module hamm_sec_codec
    import hamm_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PAR_W  = DEF_PAR_W,
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [PAR_W-1:0]  dec_syndrome_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorr_o
);

    logic [PAR_W-1:0]  syn;
    logic [DATA_W-1:0] data_fix;
    dec_status_e       status;
    dec_flags_t        flags_d, flags_q;

    hamm_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o)
    );

    hamm_syndrome #(.CODE_W(CODE_W), .SYN_W(PAR_W)) u_syn (
        .code_i (dec_code_i),
        .syn_o  (syn)
    );

    hamm_corrector #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_fix (
        .code_i   (dec_code_i),
        .syn_i    (syn),
        .data_o   (data_fix),
        .status_o (status)
    );

    assign flags_d.corrected     = (status == ST_FIXED);
    assign flags_d.uncorrectable = (status == ST_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid_o    <= 1'b0;
            dec_data_o     <= '0;
            dec_syndrome_o <= '0;
            flags_q        <= '0;
        end else begin
            dec_valid_o <= dec_valid_i;
            if (dec_valid_i) begin
                dec_data_o     <= data_fix;
                dec_syndrome_o <= syn;
                flags_q        <= flags_d;
            end
        end
    end

    assign dec_corrected_o = flags_q.corrected;
    assign dec_uncorr_o    = flags_q.uncorrectable;

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> dec_valid_o);                                                 // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> !dec_valid_o);                                               // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> $stable({dec_data_o, dec_syndrome_o, dec_corrected_o, dec_uncorr_o})); // R8
    AST_BAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        dec_uncorr_o |-> (int'(dec_syndrome_o) > CODE_W) && !dec_corrected_o);       // R5
    AST_FIX_RANGE: assert property (@(posedge clk) disable iff (rst)
        dec_corrected_o |-> (dec_syndrome_o != '0) && (int'(dec_syndrome_o) <= CODE_W)); // R4
    AST_CLEAN_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (dec_syndrome_o == '0) |-> !dec_corrected_o && !dec_uncorr_o);                // R3

endmodule

// File: tb/hamm_sec_codec_test.sv
module hamm_sec_codec_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  enc_data_i = '0;
    logic [11:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [11:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic [3:0]  dec_syndrome_o;
    logic        dec_corrected_o;
    logic        dec_uncorr_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit armed = 0;
    string cur_tag = "R3";

    hamm_sec_codec uut (
        .clk(clk), .rst(rst),
        .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_syndrome_o(dec_syndrome_o), .dec_corrected_o(dec_corrected_o),
        .dec_uncorr_o(dec_uncorr_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference: syndrome as XOR of indices of set positions.
    function automatic logic [11:0] ref_encode(logic [7:0] d);
        logic [11:0] c;
        int s, j;
        c = '0; s = 0; j = 0;
        for (int p = 1; p <= 12; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8) begin
                if (d[j]) begin c[p-1] = 1'b1; s = s ^ p; end
                j++;
            end
        end
        for (int k = 0; k < 4; k++) if ((s >> k) & 1) c[(1 << k) - 1] = 1'b1;
        return c;
    endfunction

    function automatic int ref_syn(logic [11:0] c);
        int s;
        s = 0;
        for (int p = 1; p <= 12; p++) if (c[p-1]) s = s ^ p;
        return s;
    endfunction

    function automatic logic [7:0] ref_data(logic [11:0] c);
        logic [7:0] d;
        int s, j;
        s = ref_syn(c); j = 0; d = '0;
        if (s >= 1 && s <= 12) c[s-1] = ~c[s-1];
        for (int p = 1; p <= 12; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8) begin d[j] = c[p-1]; j++; end
        end
        return d;
    endfunction

    // Cycle model of the registered decoder.
    logic       m_valid = 0, m_corr = 0, m_unc = 0;
    logic [7:0] m_data = '0;
    logic [3:0] m_syn = '0;
    string      m_tag = "R9";

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 0; m_data <= '0; m_syn <= '0; m_corr <= 0; m_unc <= 0; m_tag <= "R9";
        end else begin
            m_valid <= dec_valid_i;
            if (dec_valid_i) begin
                m_data <= ref_data(dec_code_i);
                m_syn  <= 4'(ref_syn(dec_code_i));
                m_corr <= (ref_syn(dec_code_i) >= 1) && (ref_syn(dec_code_i) <= 12);
                m_unc  <= ref_syn(dec_code_i) > 12;
                m_tag  <= cur_tag;
            end else begin
                m_tag  <= "R8";
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(m_tag == "R9" ? "R9" : "R7", "valid", int'(dec_valid_o), int'(m_valid));
            chk(m_tag, "data", int'(dec_data_o), int'(m_data));
            chk(m_tag, "syndrome", int'(dec_syndrome_o), int'(m_syn));
            chk(m_tag, "corrected", int'(dec_corrected_o), int'(m_corr));
            chk(m_tag, "uncorr", int'(dec_uncorr_o), int'(m_unc));
        end
    end

    task automatic send(logic [11:0] c, string tag);
        @(negedge clk);
        cur_tag = tag;
        dec_code_i = c;
        dec_valid_i = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_valid_i = 1'b0;
            dec_code_i = 12'hFFF;   // garbage that must not be taken
        end
    endtask

    task automatic enc_check(logic [7:0] d);
        @(negedge clk);
        enc_data_i = d;
        #1;
        chk("R1", "enc_code", int'(enc_code_o), int'(ref_encode(d)));
        chk("R2", "enc_syndrome", ref_syn(enc_code_o), 0);
    endtask

    initial begin
        logic [7:0] pats [6];
        logic [11:0] cw;
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
        @(posedge clk);
        armed = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 explicit: D0 alone sits at position 3 with P0,P1 set
        enc_check(8'h01);
        chk("R1", "D0 layout", int'(enc_code_o), 12'h007);
        foreach (pats[i]) begin
            enc_check(pats[i]);
            send(ref_encode(pats[i]), "R3");
            idle(1);
        end
        // R4: single flips at every position for two codewords
        for (int i = 0; i < 2; i++) begin
            cw = ref_encode(i == 0 ? 8'h5A : 8'hC3);
            for (int p = 1; p <= 12; p++) send(cw ^ (12'h1 << (p - 1)), "R4");
            idle(2);
        end
        // R5: syndromes 13, 14, 15 via paired flips
        cw = ref_encode(8'h96);
        send(cw ^ 12'h801, "R5");   // positions 1,12 -> 13
        send(cw ^ 12'h802, "R5");   // positions 2,12 -> 14
        send(cw ^ 12'h804, "R5");   // positions 3,12 -> 15
        idle(1);
        // R6: P0 and P1 both flipped
        send(ref_encode(8'h00) ^ 12'h003, "R6");
        send(ref_encode(8'h7E) ^ 12'h003, "R6");
        idle(3);
        // R3: triple error aliasing onto zero syndrome (positions 1,2,3)
        send(ref_encode(8'h44) ^ 12'h007, "R3");
        idle(2);
        // R9: reset mid-stream
        send(ref_encode(8'hEE) ^ 12'h010, "R4");
        @(negedge clk);
        rst = 1'b1;
        dec_valid_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        dec_valid_i = 1'b0;
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule